// File: doc/BRIEF.md
# Two-Phase Page Transfer Engine

This block moves one page of 512 bytes between a flash data port and system memory through an on-chip page buffer. Every transfer has two phases, and software arms each phase with its own register write. The internal phase runs between the flash port and the buffer. The memory phase runs between the buffer and system memory.

The direction bit sets which way the data flows. A read from the card runs the internal phase first, filling the buffer from flash, and then runs the memory phase to copy the buffer out to memory. A write from the host runs the memory phase first, filling the buffer from memory, and then runs the internal phase to send the buffer to flash.

Each phase that completes sets its own status bit, and a bus error from memory sets a third status bit. Status bits are cleared by writing ones to them. The interrupt line reports any status bit that is set and also enabled.

Top module: `dma2p_engine`

## Requirements
- R1: After a synchronous reset, these all read zero: settings (address 0), base (1), interrupt enable (2) and status (3). No port request is raised and `irq` is low. Register reads return data one cycle after `reg_raddr` is applied.
- R2: Read direction (settings bit 0 = 1). Writing settings bit 1 (internal phase) takes 128 words from the flash port into the buffer. Writing settings bit 2 (memory phase) then issues 128 memory writes of those words, in order, to base + 4*i. A request is held until it is acknowledged, and the flash and memory requests are never high together.
- R3: Write direction (bit 0 = 0). The memory phase reads 128 words from base + 4*i into the buffer. The internal phase then writes them to the flash port in the same order.
- R4: A phase whose source is a port raises its request in the cycle after the settings write is sampled.
- R5: When a phase completes, status bit 0 (internal done) or status bit 1 (memory done) is set. The active flag for that phase in the settings read-back (bit 1 internal, bit 2 memory) then returns to 0.
- R6: Writing ones to status bits clears them. If a clear and a completion hit the same bit in the same cycle, the bit ends up set.
- R7: A settings write with a phase bit set is ignored while a phase is active. A settings write with both phase bits set is always ignored.
- R8: A settings write with both phase bits zero stops an active phase. The stopped phase sets no status bit and drops its request.
- R9: A memory response that has the error flag set ends the memory phase at once and sets status bit 2.
- R10: `irq` goes high one cycle after any status bit is set while its enable bit (same position, address 2) is also set. With all enable bits clear, `irq` stays low.
- R11: The base register (address 1) ignores its low 9 bits, and those bits read back as zero. Memory addresses are word aligned.
- R12: Address 4 reads back the two capability bits. Unless both capability bits are set, no phase ever starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 3 | Register read address |
| reg_rdata | output | 32 | Registered read data |
| fl_req | output | 1 | Flash port word request |
| fl_we | output | 1 | Flash request is a write |
| fl_wdata | output | DATA_W | Word to flash |
| fl_ack | input | 1 | Flash accepts or returns a word |
| fl_rdata | input | DATA_W | Word from flash, valid with fl_ack |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Word to memory |
| mem_ack | input | 1 | Memory completes the request |
| mem_err | input | 1 | Memory error, valid with mem_ack |
| mem_rdata | input | DATA_W | Word from memory, valid with mem_ack |
| irq | output | 1 | Interrupt line |

## Verification
The completion of a phase and a software write-one-to-clear on the status register can land on the same clock edge. The bench provokes this by arming its memory model to drive a status clear on the negative edge before the final word of a memory phase is acknowledged. That clear targets both the memory-done bit and the internal-done bit that is already set. The bench then checks that the memory-done bit stays set while the internal-done bit is cleared.

// File: rtl/dma2p_pkg.sv
package dma2p_pkg;
  localparam int REG_W = 32;
  localparam int RA_W  = 3;

  localparam logic [RA_W-1:0] RA_CTRL = 3'd0;
  localparam logic [RA_W-1:0] RA_BASE = 3'd1;
  localparam logic [RA_W-1:0] RA_IEN  = 3'd2;
  localparam logic [RA_W-1:0] RA_STS  = 3'd3;
  localparam logic [RA_W-1:0] RA_CAPS = 3'd4;

  // status / enable bit positions
  localparam int ST_INT = 0;
  localparam int ST_MEM = 1;
  localparam int ST_ERR = 2;
  localparam int ST_N   = 3;

  typedef enum logic [1:0] {MV_IDLE, MV_FETCH, MV_XFER} mv_state_t;
endpackage

// File: rtl/dma2p_page_buf.sv
module dma2p_page_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 128
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DATA_W-1:0]        rdata
);
  logic [DATA_W-1:0] store [DEPTH];

  // simple dual port, registered read with enable: maps to block RAM
  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/dma2p_mover.sv
module dma2p_mover import dma2p_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WORDS  = 128
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic                          start_int,
  input  logic                          dir_rd,
  input  logic                          stop,
  input  logic [ADDR_W-$clog2(WORDS)-$clog2(DATA_W/8)-1:0] base_hi,
  output logic                          busy,
  output logic                          act_int,
  output logic                          done,
  output logic                          err,
  output logic                          fl_req,
  output logic                          fl_we,
  input  logic                          fl_ack,
  input  logic [DATA_W-1:0]             fl_rdata,
  output logic                          mem_req,
  output logic                          mem_we,
  output logic [ADDR_W-1:0]             mem_addr,
  input  logic                          mem_ack,
  input  logic                          mem_err,
  input  logic [DATA_W-1:0]             mem_rdata,
  output logic                          buf_re,
  output logic [$clog2(WORDS)-1:0]      buf_raddr,
  output logic                          buf_we,
  output logic [$clog2(WORDS)-1:0]      buf_waddr,
  output logic [DATA_W-1:0]             buf_wdata
);
  localparam int IDX_W  = $clog2(WORDS);
  localparam int BYTE_W = $clog2(DATA_W/8);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

  mv_state_t        state;
  logic             phase_int;
  logic             from_buf;
  logic [IDX_W-1:0] idx;

  logic             ack, bad, beat, start_from_buf;

  assign start_from_buf = start_int ? !dir_rd : dir_rd;
  assign ack  = phase_int ? fl_ack : mem_ack;
  assign bad  = !phase_int && mem_err;
  assign beat = (state == MV_XFER) && ack;
  assign done = beat && !bad && (idx == LAST);
  assign err  = beat && bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= MV_IDLE;
      phase_int <= 1'b0;
      from_buf  <= 1'b0;
      idx       <= '0;
    end else if (stop) begin
      state <= MV_IDLE;
    end else begin
      unique case (state)
        MV_IDLE: if (start) begin
          phase_int <= start_int;
          from_buf  <= start_from_buf;
          idx       <= '0;
          state     <= start_from_buf ? MV_FETCH : MV_XFER;
        end
        MV_FETCH: state <= MV_XFER;
        MV_XFER: if (beat) begin
          if (bad || idx == LAST) state <= MV_IDLE;
          else begin
            idx   <= idx + 1'b1;
            state <= from_buf ? MV_FETCH : MV_XFER;
          end
        end
        default: state <= MV_IDLE;
      endcase
    end
  end

  assign busy      = (state != MV_IDLE);
  assign act_int   = phase_int;
  assign fl_req    = (state == MV_XFER) && phase_int;
  assign mem_req   = (state == MV_XFER) && !phase_int;
  assign fl_we     = from_buf;
  assign mem_we    = from_buf;
  assign mem_addr  = {base_hi, idx, {BYTE_W{1'b0}}};
  assign buf_re    = (state == MV_FETCH);
  assign buf_raddr = idx;
  assign buf_we    = beat && !from_buf && !bad;
  assign buf_waddr = idx;
  assign buf_wdata = phase_int ? fl_rdata : mem_rdata;
endmodule

// File: rtl/dma2p_engine.sv
module dma2p_engine import dma2p_pkg::*; #(
  parameter int         ADDR_W     = 32,
  parameter int         DATA_W     = 32,
  parameter int         PAGE_BYTES = 512,
  parameter logic [1:0] CAPS       = 2'b11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [RA_W-1:0]   reg_raddr,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              fl_req,
  output logic              fl_we,
  output logic [DATA_W-1:0] fl_wdata,
  input  logic              fl_ack,
  input  logic [DATA_W-1:0] fl_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              irq
);
  localparam int BPW   = DATA_W / 8;
  localparam int WORDS = PAGE_BYTES / BPW;
  localparam int IDX_W = $clog2(WORDS);
  localparam int OFS_W = $clog2(PAGE_BYTES);
  localparam int HI_W  = ADDR_W - OFS_W;

  logic             dir_q;
  logic [HI_W-1:0]  base_q;
  logic [ST_N-1:0]  ien_q, sts_q, sts_set, sts_clr;
  logic             irq_q;

  logic             mv_busy, mv_int, mv_done, mv_err;
  logic             buf_re, buf_we;
  logic [IDX_W-1:0] buf_raddr, buf_waddr;
  logic [DATA_W-1:0] buf_wdata, buf_q;

  logic             ctrl_wr, dma_ok, mv_start, mv_stop;
  logic [1:0]       phase_bits;
  logic             unused_bits;

  assign unused_bits = ^{reg_wdata[REG_W-1:ADDR_W], reg_wdata[OFS_W-1:ST_N]};

  generate
    if (CAPS == 2'b11) begin : g_cap_ok
      assign dma_ok = 1'b1;
    end else begin : g_cap_no
      assign dma_ok = 1'b0;
    end
  endgenerate

  assign ctrl_wr    = reg_wr && (reg_addr == RA_CTRL);
  assign phase_bits = reg_wdata[2:1];
  assign mv_stop    = ctrl_wr && (phase_bits == 2'b00);
  assign mv_start   = ctrl_wr && dma_ok && !mv_busy &&
                      (phase_bits == 2'b01 || phase_bits == 2'b10);

  assign sts_set = {mv_err, mv_done && !mv_int, mv_done && mv_int};
  assign sts_clr = (reg_wr && reg_addr == RA_STS) ? reg_wdata[ST_N-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= 1'b0;
      base_q <= '0;
      ien_q  <= '0;
      sts_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mv_start || mv_stop) dir_q <= reg_wdata[0];
      if (reg_wr && reg_addr == RA_BASE) base_q <= reg_wdata[ADDR_W-1:OFS_W];
      if (reg_wr && reg_addr == RA_IEN) ien_q <= reg_wdata[ST_N-1:0];
      sts_q <= (sts_q & ~sts_clr) | sts_set;
      irq_q <= |(sts_q & ien_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      unique case (reg_raddr)
        RA_CTRL: reg_rdata <= REG_W'({mv_busy && !mv_int, mv_busy && mv_int, dir_q});
        RA_BASE: reg_rdata <= REG_W'({base_q, {OFS_W{1'b0}}});
        RA_IEN:  reg_rdata <= REG_W'(ien_q);
        RA_STS:  reg_rdata <= REG_W'(sts_q);
        RA_CAPS: reg_rdata <= REG_W'(CAPS);
        default: reg_rdata <= '0;
      endcase
    end
  end

  assign irq = irq_q;

  dma2p_mover #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_mover (
    .clk(clk), .rst(rst),
    .start(mv_start), .start_int(phase_bits[0]), .dir_rd(reg_wdata[0]), .stop(mv_stop),
    .base_hi(base_q),
    .busy(mv_busy), .act_int(mv_int), .done(mv_done), .err(mv_err),
    .fl_req(fl_req), .fl_we(fl_we), .fl_ack(fl_ack), .fl_rdata(fl_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
    .buf_re(buf_re), .buf_raddr(buf_raddr),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata)
  );

  dma2p_page_buf #(.DATA_W(DATA_W), .DEPTH(WORDS)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .re(buf_re), .raddr(buf_raddr), .rdata(buf_q)
  );

  assign fl_wdata  = buf_q;
  assign mem_wdata = buf_q;
endmodule

// File: rtl/dma2p_engine_chk.sv
module dma2p_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              fl_req,
  input logic              fl_ack,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_err,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              irq,
  input logic              mv_done,
  input logic              mv_int,
  input logic [2:0]        sts_q,
  input logic [2:0]        ien_q
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(DATA_W/8 - 1);
  logic ctrl_wr;
  assign ctrl_wr = reg_wr && (reg_addr == 3'd0);

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!fl_req && !mem_req && !irq));

  p_one_port_r2: assert property (@(posedge clk) disable iff (rst)
    !(fl_req && mem_req));

  p_fl_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (fl_req && !fl_ack && !ctrl_wr) |=> fl_req);

  p_mem_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack && !ctrl_wr) |=> (mem_req && $stable(mem_addr)));

  p_word_align_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> ((mem_addr & LOW_MASK) == '0));

  p_done_sets_r5: assert property (@(posedge clk) disable iff (rst)
    (mv_done && mv_int) |=> sts_q[0]);

  p_busy_ignore_r7: assert property (@(posedge clk) disable iff (rst)
    (fl_req && !fl_ack && ctrl_wr && reg_wdata[2:1] != 2'b00) |=> fl_req);

  p_err_ends_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack && mem_err) |=> !mem_req);

  p_mask_r10: assert property (@(posedge clk) disable iff (rst)
    (ien_q == 3'b000) |=> !irq);
endmodule

bind dma2p_engine dma2p_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .fl_req(fl_req), .fl_ack(fl_ack), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_err(mem_err), .mem_addr(mem_addr), .irq(irq),
  .mv_done(mv_done), .mv_int(mv_int), .sts_q(sts_q), .ien_q(ien_q)
);

// File: tb/test_dma2p_engine.sv
`timescale 1ns/1ps
module test_dma2p_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        drv_wr = 1'b0;
  logic [2:0]  drv_addr = '0;
  logic [31:0] drv_wdata = '0;
  logic        clr_wr = 1'b0;
  logic [2:0]  clr_mask = '0;
  logic        reg_wr_w;
  logic [2:0]  reg_addr_w;
  logic [31:0] reg_wdata_w;
  assign reg_wr_w    = drv_wr | clr_wr;
  assign reg_addr_w  = clr_wr ? 3'd3 : drv_addr;
  assign reg_wdata_w = clr_wr ? {29'd0, clr_mask} : drv_wdata;

  logic [2:0]  raddr = '0;
  logic [31:0] rdata, lim_rdata;
  logic        fl_req, fl_we, fl_ack = 1'b0;
  logic [31:0] fl_wdata, fl_rdata = '0;
  logic        mem_req, mem_we, mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic        irq;
  logic        lim_fl_req, lim_fl_we, lim_mem_req, lim_mem_we, lim_irq;
  logic [31:0] lim_fl_wdata, lim_mem_addr, lim_mem_wdata;

  dma2p_engine i_dma2p_engine (
    .clk(clk), .rst(rst), .reg_wr(reg_wr_w), .reg_addr(reg_addr_w), .reg_wdata(reg_wdata_w),
    .reg_raddr(raddr), .reg_rdata(rdata),
    .fl_req(fl_req), .fl_we(fl_we), .fl_wdata(fl_wdata), .fl_ack(fl_ack), .fl_rdata(fl_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata), .irq(irq)
  );

  dma2p_engine #(.CAPS(2'b01)) i_dma2p_engine_lim (
    .clk(clk), .rst(rst), .reg_wr(reg_wr_w), .reg_addr(reg_addr_w), .reg_wdata(reg_wdata_w),
    .reg_raddr(raddr), .reg_rdata(lim_rdata),
    .fl_req(lim_fl_req), .fl_we(lim_fl_we), .fl_wdata(lim_fl_wdata), .fl_ack(1'b0), .fl_rdata(32'd0),
    .mem_req(lim_mem_req), .mem_we(lim_mem_we), .mem_addr(lim_mem_addr), .mem_wdata(lim_mem_wdata),
    .mem_ack(1'b0), .mem_err(1'b0), .mem_rdata(32'd0), .irq(lim_irq)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [63:0] exp_q[$];
  logic [31:0] sys_mem [2048];
  int   fl_cnt = 0;
  int   cyc = 0;
  logic stall_en = 1'b0, err_en = 1'b0, clr_arm = 1'b0, lim_bad = 1'b0;
  logic [6:0] err_beat = '0;
  logic [6:0] beat;

  function automatic logic [31:0] fword(int n);
    return (n * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction
  function automatic logic [31:0] mword(int j);
    return j * 32'h01010101 + 32'hC0DE0000;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compare one produced write against the queue front
  task automatic mon(input logic kind, input logic [31:0] a, input logic [31:0] d);
    logic [63:0] e;
    if (exp_q.size() == 0) begin
      n_chk++; n_err++;
      $display("FAIL %s unexpected write: actual=%0h expected=none", kind ? "R2" : "R3", d);
    end else begin
      e = exp_q.pop_front();
      if (kind) check("R2 mem addr", a, {1'b0, e[62:32]});
      check(kind ? "R2 write data" : "R3 flash data", d, e[31:0]);
      check(kind ? "R2 port kind" : "R3 port kind", {31'd0, kind}, {31'd0, e[63]});
    end
  endtask

  // memory/flash model plus monitor, away from the active edge
  always @(negedge clk) begin
    cyc++;
    clr_wr  = 1'b0;
    fl_ack  = 1'b0;
    mem_ack = 1'b0;
    mem_err = 1'b0;
    if (!rst) begin
      if (fl_req && !(stall_en && (cyc % 3 == 1))) begin
        fl_ack = 1'b1;
        if (fl_we) mon(1'b0, 32'd0, fl_wdata);
        else begin fl_rdata = fword(fl_cnt); fl_cnt++; end
      end
      if (mem_req && !(stall_en && (cyc % 4 == 2))) begin
        mem_ack = 1'b1;
        beat = mem_addr[8:2];
        if (err_en && beat == err_beat) mem_err = 1'b1;
        if (mem_we) mon(1'b1, mem_addr, mem_wdata);
        else mem_rdata = sys_mem[mem_addr[12:2]];
        if (clr_arm && beat == 7'd127) clr_wr = 1'b1;
      end
      if (lim_fl_req || lim_mem_req) lim_bad = 1'b1;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); drv_wr = 1'b1; drv_addr = a; drv_wdata = d;
    @(negedge clk); drv_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); raddr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic wait_sts(input logic [2:0] mask, input string tag);
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      rd(3'd3, v);
      if ((v[2:0] & mask) != 0) return;
    end
    check({tag, " completion timeout"}, 32'd0, 32'd1);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int cnt0;
    for (int j = 0; j < 2048; j++) sys_mem[j] = 32'hDEAD0000;
    for (int i = 0; i < 128; i++) sys_mem[32'h100 + i] = mword(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 fl_req", {31'd0, fl_req}, 0);
    check("R1 mem_req", {31'd0, mem_req}, 0);
    check("R1 irq", {31'd0, irq}, 0);
    for (int a = 0; a < 4; a++) begin
      rd(3'(a), v);
      check("R1 register", v, 0);
    end
    // R12 capability read-back
    @(negedge clk); raddr = 3'd4;
    @(negedge clk);
    check("R12 caps", rdata, 32'd3);
    check("R12 limited caps", lim_rdata, 32'd1);

    // R11 alignment of base register
    wr(3'd1, 32'h0000_13FF);
    rd(3'd1, v);
    check("R11 base readback", v, 32'h0000_1200);

    // R2/R4 read direction, internal phase
    wr(3'd2, 32'd7);
    cnt0 = fl_cnt;
    wr(3'd0, 32'b011);
    check("R4 request next cycle", {31'd0, fl_req}, 1);
    repeat (8) @(negedge clk);
    wr(3'd0, 32'b101);              // R7 ignored while busy
    rd(3'd0, v);
    check("R7 busy write ignored", v, 32'b011);
    wait_sts(3'b001, "R2");
    rd(3'd3, v);
    check("R5 internal done", v, 32'b001);
    rd(3'd0, v);
    check("R5 active flag dropped", v, 32'b001);
    repeat (2) @(negedge clk);
    check("R10 irq raised", {31'd0, irq}, 1);

    // R2 memory phase with simultaneous clear at completion (R6)
    for (int i = 0; i < 128; i++)
      exp_q.push_back({1'b1, 31'(32'h1200 + 4 * i), fword(cnt0 + i)});
    clr_mask = 3'b011;
    clr_arm  = 1'b1;
    wr(3'd0, 32'b101);
    wait_sts(3'b010, "R2");
    clr_arm = 1'b0;
    rd(3'd3, v);
    check("R6 set wins over clear", v, 32'b010);
    check("R2 all writes seen", exp_q.size(), 0);
    wr(3'd3, 32'b010);
    rd(3'd3, v);
    check("R6 write one clears", v, 32'b000);

    // R3 write direction with stalls
    stall_en = 1'b1;
    wr(3'd1, 32'h0000_0400);
    wr(3'd0, 32'b100);
    wait_sts(3'b010, "R3");
    rd(3'd0, v);
    check("R5 memory flag dropped", v, 32'b000);
    wr(3'd3, 32'b010);
    for (int i = 0; i < 128; i++) exp_q.push_back({1'b0, 31'd0, mword(i)});
    wr(3'd0, 32'b010);
    wait_sts(3'b001, "R3");
    rd(3'd3, v);
    check("R3 internal done", v, 32'b001);
    check("R3 all flash writes seen", exp_q.size(), 0);
    wr(3'd3, 32'b001);
    stall_en = 1'b0;

    // R9 memory error ends the phase
    wr(3'd1, 32'h0000_1200);
    err_beat = 7'd5;
    err_en   = 1'b1;
    for (int i = 0; i < 6; i++)
      exp_q.push_back({1'b1, 31'(32'h1200 + 4 * i), mword(i)});
    wr(3'd0, 32'b101);
    wait_sts(3'b100, "R9");
    err_en = 1'b0;
    rd(3'd3, v);
    check("R9 error status only", v, 32'b100);
    rd(3'd0, v);
    check("R9 phase ended", v, 32'b001);
    check("R9 no more memory requests", {31'd0, mem_req}, 0);
    check("R9 writes before error", exp_q.size(), 0);

    // R10 masking
    wr(3'd2, 32'd0);
    repeat (2) @(negedge clk);
    check("R10 masked irq", {31'd0, irq}, 0);
    wr(3'd2, 32'b100);
    repeat (2) @(negedge clk);
    check("R10 enabled irq", {31'd0, irq}, 1);
    wr(3'd3, 32'b100);
    repeat (2) @(negedge clk);
    check("R10 irq after clear", {31'd0, irq}, 0);
    wr(3'd2, 32'd7);

    // R8 stop by zero write
    wr(3'd0, 32'b011);
    repeat (15) @(negedge clk);
    wr(3'd0, 32'b000);
    repeat (3) @(negedge clk);
    check("R8 request dropped", {31'd0, fl_req}, 0);
    rd(3'd0, v);
    check("R8 flags clear", v, 32'b000);
    repeat (200) @(negedge clk);
    rd(3'd3, v);
    check("R8 no status", v, 32'b000);

    // R7 both phase bits ignored
    wr(3'd0, 32'b111);
    repeat (3) @(negedge clk);
    check("R7 both bits no request", {31'd0, fl_req | mem_req}, 0);
    rd(3'd0, v);
    check("R7 both bits state", v, 32'b000);

    // R12 limited instance never requested
    check("R12 no start without caps", {31'd0, lim_bad}, 0);
    finish_run();
  end
endmodule